// File: doc/BRIEF.md
# Page-Received Latched Status Register

This block holds the status that auto-negotiation software polls while pages are being exchanged with a link partner. The negotiation engine sends single-cycle strobes. One says a page has arrived, one says the partner can exchange next pages, and one says a new negotiation has begun. A level tells whether the arriving page is the base page. Sticky bits keep these events until software reads them, so a poller cannot miss a short event.

Software reads through a simple port: an address, a read strobe and registered read data. Reading the page status register (address 6) is destructive. It clears the latched page-received and partner-next-page bits. It also clears a mirror of page-received held in a vendor status register (address 16), so one read clears bits in two registers. The base-page indication is a live status. It follows the type of the most recent page and is never cleared by a read.

Top module: `pgstat_regs`

## Requirements
- R1: After reset, every bit of both registers is zero, and `rd_data` is zero.
- R2: A pulse on `evt_page_rx` sets the page-received bit (address 6, bit 1). The bit stays set until address 6 is read.
- R3: A read returns its data on `rd_data` in the cycle after `rd_en`. The data holds the register value from before the read. A read of address 6 clears the page-received and partner-next-page bits from the following cycle.
- R4: A pulse on `evt_page_rx` also sets the vendor mirror bit (address 16, bit 1). Only a read of address 6 clears it; a read of address 16 leaves it set.
- R5: A pulse on `evt_np_able` sets the partner-next-page bit (address 6, bit 2). The bit stays set until address 6 is read.
- R6: A pulse on `evt_neg_start` clears the partner-next-page bit. If `evt_np_able` arrives in the same cycle, the bit stays set.
- R7: The base-page bit (address 6, bit 5) takes the value of `evt_base_page` at each `evt_page_rx` pulse. Reads and `evt_neg_start` do not change it.
- R8: If a set event and a clearing read of address 6 fall in the same cycle, the bit stays set. The read returns the value from before the event.
- R9: Unused bit positions, unmapped addresses, and cycles without a read in the previous cycle all give zero on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | 5 | Register address for a read |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 16 | Registered read data, valid the cycle after `rd_en` |
| evt_page_rx | input | 1 | Strobe: a page was received |
| evt_base_page | input | 1 | Level, sampled with `evt_page_rx`: the page is the base page |
| evt_np_able | input | 1 | Strobe: the partner advertises next-page ability |
| evt_neg_start | input | 1 | Strobe: a new negotiation has started |

## Verification
The assertions check several rules on every cycle. A page strobe always sets page-received. A read of address 6 with no competing event always clears it. The vendor mirror always tracks page-received. A negotiation restart with no capability strobe always clears the next-page bit. The base-page bit holds when no page arrives. Read data is zero in any cycle that follows no read. Other behaviour needs the bench's directed scenarios, which show it as register values seen through the read port. These scenarios cover the pre-clear value returned by a read, a vendor-register read that leaves its bit set, the event-versus-clear collision, and the zero result for unmapped addresses.

// File: rtl/pgstat_pkg.sv
package pgstat_pkg;

  // Snapshot of all status storage handed to the read path.
  typedef struct packed {
    logic page_rcvd;
    logic partner_np;
    logic base_page;
    logic vend_pr;
  } pgstat_t;

  // Indices into the vector of sticky bits.
  localparam int unsigned STK_PR  = 0;
  localparam int unsigned STK_NP  = 1;
  localparam int unsigned STK_VPR = 2;
  localparam int unsigned STK_NUM = 3;

endpackage

// File: rtl/pgstat_sticky.sv
// One latched status bit. A set request can be given priority over a
// clear request in the same cycle.
module pgstat_sticky #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_nxt;

  generate
    if (SET_WINS) begin : g_set_first
      always_comb begin
        if (set_i)      q_nxt = 1'b1;
        else if (clr_i) q_nxt = 1'b0;
        else            q_nxt = q_o;
      end
    end else begin : g_clr_first
      always_comb begin
        if (clr_i)      q_nxt = 1'b0;
        else if (set_i) q_nxt = 1'b1;
        else            q_nxt = q_o;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= q_nxt;
  end

endmodule

// File: rtl/pgstat_rdmux.sv
// Maps the status snapshot onto the read address space (combinational).
module pgstat_rdmux
  import pgstat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PAGE_ADDR = 6,
  parameter int unsigned VEND_ADDR = 16,
  parameter int unsigned PR_BIT    = 1,
  parameter int unsigned NP_BIT    = 2,
  parameter int unsigned BASE_BIT  = 5,
  parameter int unsigned VPR_BIT   = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  pgstat_t           st_i,
  output logic [DATA_W-1:0] word_o,
  output logic              hit_page_o
);

  localparam logic [ADDR_W-1:0] PAGE_A = ADDR_W'(PAGE_ADDR);
  localparam logic [ADDR_W-1:0] VEND_A = ADDR_W'(VEND_ADDR);

  logic [DATA_W-1:0] page_word;
  logic [DATA_W-1:0] vend_word;

  always_comb begin
    page_word           = '0;
    page_word[PR_BIT]   = st_i.page_rcvd;
    page_word[NP_BIT]   = st_i.partner_np;
    page_word[BASE_BIT] = st_i.base_page;
    vend_word           = '0;
    vend_word[VPR_BIT]  = st_i.vend_pr;
  end

  assign hit_page_o = (addr_i == PAGE_A);

  always_comb begin
    if (addr_i == PAGE_A)      word_o = page_word;
    else if (addr_i == VEND_A) word_o = vend_word;
    else                       word_o = '0;
  end

endmodule

// File: rtl/pgstat_regs.sv
module pgstat_regs
  import pgstat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PAGE_ADDR = 6,
  parameter int unsigned VEND_ADDR = 16,
  parameter int unsigned PR_BIT    = 1,
  parameter int unsigned NP_BIT    = 2,
  parameter int unsigned BASE_BIT  = 5,
  parameter int unsigned VPR_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              evt_page_rx,
  input  logic              evt_base_page,
  input  logic              evt_np_able,
  input  logic              evt_neg_start
);

  logic [STK_NUM-1:0] stk_set;
  logic [STK_NUM-1:0] stk_clr;
  logic [STK_NUM-1:0] stk_q;
  logic               base_q;
  logic               hit_page;
  logic               clr_rd;
  logic [DATA_W-1:0]  word;
  pgstat_t            st;

  // Destructive read of the page status register.
  assign clr_rd = rd_en && hit_page;

  always_comb begin
    stk_set          = '0;
    stk_clr          = '0;
    stk_set[STK_PR]  = evt_page_rx;
    stk_clr[STK_PR]  = clr_rd;
    stk_set[STK_NP]  = evt_np_able;
    stk_clr[STK_NP]  = clr_rd || evt_neg_start;
    stk_set[STK_VPR] = evt_page_rx;
    stk_clr[STK_VPR] = clr_rd;
  end

  generate
    for (genvar i = 0; i < STK_NUM; i++) begin : g_stk
      pgstat_sticky #(.SET_WINS(1'b1)) u_bit (
        .clk   (clk),
        .rst   (rst),
        .set_i (stk_set[i]),
        .clr_i (stk_clr[i]),
        .q_o   (stk_q[i])
      );
    end
  endgenerate

  // Live page-type flag, refreshed on every received page.
  always_ff @(posedge clk) begin
    if (rst)              base_q <= 1'b0;
    else if (evt_page_rx) base_q <= evt_base_page;
  end

  always_comb begin
    st.page_rcvd  = stk_q[STK_PR];
    st.partner_np = stk_q[STK_NP];
    st.vend_pr    = stk_q[STK_VPR];
    st.base_page  = base_q;
  end

  pgstat_rdmux #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PAGE_ADDR(PAGE_ADDR),
    .VEND_ADDR(VEND_ADDR),
    .PR_BIT   (PR_BIT),
    .NP_BIT   (NP_BIT),
    .BASE_BIT (BASE_BIT),
    .VPR_BIT  (VPR_BIT)
  ) u_mux (
    .addr_i    (rd_addr),
    .st_i      (st),
    .word_o    (word),
    .hit_page_o(hit_page)
  );

  // Registered read data: the snapshot is taken at the same edge that
  // applies the clear, so the pre-clear value is returned.
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= word;
    else            rd_data <= '0;
  end

endmodule

// File: rtl/pgstat_regs_chk.sv
module pgstat_regs_chk #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PAGE_ADDR = 6,
  parameter int unsigned PR_BIT    = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              evt_page_rx,
  input logic              evt_np_able,
  input logic              evt_neg_start,
  input logic [2:0]        stk_q,
  input logic              base_q
);

  logic rd_page;
  assign rd_page = rd_en && (rd_addr == ADDR_W'(PAGE_ADDR));

  // R2
  p_pr_set_r2: assert property (@(posedge clk) disable iff (rst)
    evt_page_rx |=> stk_q[0]);

  // R3
  p_pr_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_page && !evt_page_rx) |=> !stk_q[0]);

  // R3 / R8: the read returns the value held before the edge
  p_rd_old_r3: assert property (@(posedge clk) disable iff (rst)
    rd_page |=> (rd_data[PR_BIT] == $past(stk_q[0])));

  // R4
  p_mirror_r4: assert property (@(posedge clk) disable iff (rst)
    stk_q[2] == stk_q[0]);

  // R6
  p_np_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_neg_start && !evt_np_able) |=> !stk_q[1]);

  // R7
  p_base_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !evt_page_rx |=> $stable(base_q));

  // R9
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));

endmodule

bind pgstat_regs pgstat_regs_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PAGE_ADDR(PAGE_ADDR),
  .PR_BIT   (PR_BIT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rd_addr      (rd_addr),
  .rd_en        (rd_en),
  .rd_data      (rd_data),
  .evt_page_rx  (evt_page_rx),
  .evt_np_able  (evt_np_able),
  .evt_neg_start(evt_neg_start),
  .stk_q        (stk_q),
  .base_q       (base_q)
);

// File: tb/pgstat_regs_test.sv
`timescale 1ns/1ps
module pgstat_regs_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_addr = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        evt_page_rx = 1'b0;
  logic        evt_base_page = 1'b0;
  logic        evt_np_able = 1'b0;
  logic        evt_neg_start = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pgstat_regs uut (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data),
    .evt_page_rx(evt_page_rx), .evt_base_page(evt_base_page),
    .evt_np_able(evt_np_able), .evt_neg_start(evt_neg_start)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // One-cycle read; data is sampled at the following negedge.
  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(input logic pg, input logic base, input logic np, input logic neg);
    @(negedge clk);
    evt_page_rx = pg; evt_base_page = base; evt_np_able = np; evt_neg_start = neg;
    @(negedge clk);
    evt_page_rx = 1'b0; evt_base_page = 1'b0; evt_np_able = 1'b0; evt_neg_start = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 rd_data after reset", rd_data, 16'h0000);
    rd(5'd6, d);  check("R1 page reg after reset", d, 16'h0000);
    rd(5'd16, d); check("R1 vendor reg after reset", d, 16'h0000);
  endtask

  task automatic t_page_and_mirror();
    logic [15:0] d;
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    rd(5'd16, d); check("R4 mirror set", d, 16'h0002);
    rd(5'd16, d); check("R4 vendor read keeps mirror", d, 16'h0002);
    rd(5'd6, d);  check("R2 page received latched", d, 16'h0002);
    rd(5'd6, d);  check("R3 page read clears", d, 16'h0000);
    rd(5'd16, d); check("R4 mirror cleared by page read", d, 16'h0000);
  endtask

  task automatic t_np_and_base();
    logic [15:0] d;
    pulse(1'b1, 1'b1, 1'b1, 1'b0);
    rd(5'd6, d); check("R5 np and base latched", d, 16'h0026);
    rd(5'd6, d); check("R7 base survives read", d, 16'h0020);
  endtask

  task automatic t_restart();
    logic [15:0] d;
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    pulse(1'b0, 1'b0, 1'b0, 1'b1);
    rd(5'd6, d); check("R6 restart clears np, R7 base kept", d, 16'h0020);
    pulse(1'b0, 1'b0, 1'b1, 1'b1);
    rd(5'd6, d); check("R6 np wins over restart", d, 16'h0024);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    @(negedge clk);
    rd_addr = 5'd6; rd_en = 1'b1; evt_page_rx = 1'b1; evt_base_page = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; evt_page_rx = 1'b0; evt_base_page = 1'b0;
    check("R8 read returns pre-event value", rd_data, 16'h0020);
    rd(5'd6, d); check("R8 event wins over clear", d, 16'h0022);
  endtask

  task automatic t_base_follow();
    logic [15:0] d;
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    rd(5'd6, d); check("R7 base follows non-base page", d, 16'h0002);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    pulse(1'b1, 1'b1, 1'b1, 1'b0);
    rd(5'd3, d);  check("R9 unmapped address reads zero", d, 16'h0000);
    @(negedge clk);
    check("R9 idle cycle reads zero", rd_data, 16'h0000);
    rd(5'd6, d);  check("R9 unmapped read did not clear", d, 16'h0026);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_page_and_mirror();
    t_np_and_base();
    t_restart();
    t_collision();
    t_base_follow();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule